// File: doc/BRIEF.md
# Bus Comparator Trigger Sequencer

The block watches a processor bus one cycle at a time. Each cycle carries a valid strobe, an address, a data word and a two-bit cycle-type code. Two programmable comparators, A and B, feed a trigger engine with nine fixed combinations. These combinations cover single matches, alternation, ordered sequencing (A first, then B), data qualification, event-only data capture and inclusive or exclusive address windows. A qualifying cycle produces a one-cycle trigger pulse. The event-only modes also produce the data word of the matching cycle.

The trigger can also raise a breakpoint request. A tagged breakpoint accepts only a match on an instruction-start cycle. A forced breakpoint waits for the next instruction-start cycle after the match. A third address comparator, C, gives one more breakpoint source with its own tag/force choice. C is idle whenever the trace logic is set to its loop-suppression capture mode. The request is a level that stays set until it is acknowledged. It is reported on one of two outputs: debug-mode entry or software interrupt.

All settings come through a small register-write port: a control word and three comparator values.

Top module: `bus_trigger_seq`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_addr`: 0 selects control, 1 selects the A value, 2 selects the B value, 3 selects the C value. Control bits are: [3:0] mode, [4] full, [5] A enable, [6] B enable, [7] C enable, [8] A/B tag, [9] C tag, [10] software-interrupt action, [11] loop-suppression.
- R2: A comparator matches only in a cycle with `bus_valid` high and its enable bit set. When the full bit is 0, B compares the address. When the full bit is 1, B compares the data. A disabled comparator never matches.
- R3: Mode 0 (A), mode 1 (A or B) and mode 5 (B event) raise `trig` for exactly one cycle, in the cycle after the qualifying bus cycle.
- R4: Mode 2 (A then B) and mode 6 (A then B event) fire on a B match only after A has matched in an earlier cycle. Firing, or any configuration write, clears the armed state.
- R5: Mode 3 (A and B) fires when A and B match in the same cycle. Mode 4 (A and not B) fires when A matches and B does not. Both modes fire only when the full bit is 1. Mode codes 9 to 15 never fire.
- R6: Mode 7 fires when A ≤ address ≤ B, compared unsigned. Mode 8 fires when the address lies outside that window. Both modes need both enables set.
- R7: When mode 5 or mode 6 fires, `evt_valid` pulses together with `trig`, and `evt_data` holds that cycle's data word. In every other case `evt_valid` stays low.
- R8: With the A/B tag bit set, a trigger counts only on a cycle whose `bus_ctype` is 2'b01 (instruction start). The breakpoint request then rises together with `trig`.
- R9: With the A/B tag bit clear, a match sets a pending flag. The request rises one cycle after the first later valid cycle whose `bus_ctype` is 2'b01.
- R10: The request stays high until `bp_clr` is sampled high. The action bit, sampled when the request rises, routes the request to `bp_swi_req` when it is 1 and to `bp_dbg_req` when it is 0.
- R11: Comparator C matches the address. It raises a tagged or forced request as set by the C tag bit. It never matches while the loop-suppression bit is set.
- R12: After reset, all registers read 0, and `trig`, `evt_valid` and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | CFG_W | Configuration write data |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data word |
| bus_ctype | input | 2 | Cycle type, 2'b01 = instruction start |
| bp_clr | input | 1 | Breakpoint acknowledge |
| trig | output | 1 | One-cycle trigger pulse |
| evt_valid | output | 1 | Event data strobe |
| evt_data | output | DW | Captured event data |
| bp_dbg_req | output | 1 | Debug-entry breakpoint request |
| bp_swi_req | output | 1 | Software-interrupt breakpoint request |

## Verification
The bench builds the block with AW = DW = 4 and CFG_W = 12. At that size the whole 16-entry address space can be visited under every mode code from 0 to 9, both full settings and all four A/B enable combinations. Two passes with shifted data words make every ordering of A and B events occur: same cycle, A before B, and B with no A. Directed sequences then cover tag versus force timing, acknowledge, the action routing and the comparator C gating.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int CTRL_W = 12;

  localparam logic [3:0] MODE_A          = 4'd0;
  localparam logic [3:0] MODE_A_OR_B     = 4'd1;
  localparam logic [3:0] MODE_A_THEN_B   = 4'd2;
  localparam logic [3:0] MODE_A_AND_B    = 4'd3;
  localparam logic [3:0] MODE_A_NOT_B    = 4'd4;
  localparam logic [3:0] MODE_EVT_B      = 4'd5;
  localparam logic [3:0] MODE_A_THEN_EVT = 4'd6;
  localparam logic [3:0] MODE_INSIDE     = 4'd7;
  localparam logic [3:0] MODE_OUTSIDE    = 4'd8;

  localparam logic [1:0] CT_INSN = 2'b01;

  typedef struct packed {
    logic       loop_sup;
    logic       act_swi;
    logic       tag_c;
    logic       tag_ab;
    logic       en_c;
    logic       en_b;
    logic       en_a;
    logic       full;
    logic [3:0] mode;
  } ctrl_t;
endpackage

// File: rtl/bts_cfg_regs.sv
module bts_cfg_regs
  import bts_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CFG_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [1:0]                           cfg_addr,
  input  logic [CFG_W-1:0]                     cfg_wdata,
  output ctrl_t                                ctrl_o,
  output logic [AW-1:0]                        a_val_o,
  output logic [((AW > DW) ? AW : DW)-1:0]     b_val_o,
  output logic [AW-1:0]                        c_val_o,
  output logic                                 cfg_wr_o
);
  localparam int BW = (AW > DW) ? AW : DW;

  ctrl_t          ctrl_q, ctrl_d;
  logic [AW-1:0]  a_q, a_d, c_q, c_d;
  logic [BW-1:0]  b_q, b_d;

  always_comb begin
    ctrl_d = ctrl_q;
    a_d    = a_q;
    b_d    = b_q;
    c_d    = c_q;
    if (cfg_we) begin
      unique case (cfg_addr)
        2'd0: ctrl_d = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        2'd1: a_d    = cfg_wdata[AW-1:0];
        2'd2: b_d    = cfg_wdata[BW-1:0];
        default: c_d = cfg_wdata[AW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
    end else if (cfg_we) begin
      ctrl_q <= ctrl_d;
      a_q    <= a_d;
      b_q    <= b_d;
      c_q    <= c_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign a_val_o  = a_q;
  assign b_val_o  = b_q;
  assign c_val_o  = c_q;
  assign cfg_wr_o = cfg_we;
endmodule

// File: rtl/bts_comparators.sv
module bts_comparators #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic                             valid_i,
  input  logic [AW-1:0]                    addr_i,
  input  logic [DW-1:0]                    data_i,
  input  logic                             full_i,
  input  logic                             en_a_i,
  input  logic                             en_b_i,
  input  logic                             en_c_i,
  input  logic                             loop_sup_i,
  input  logic [AW-1:0]                    a_val_i,
  input  logic [((AW > DW) ? AW : DW)-1:0] b_val_i,
  input  logic [AW-1:0]                    c_val_i,
  output logic                             ma_o,
  output logic                             mb_o,
  output logic                             mc_o,
  output logic                             in_rng_o,
  output logic                             out_rng_o
);
  localparam int NADDR = 2;

  logic [AW-1:0] ref_v [NADDR];
  logic          en_v  [NADDR];
  logic          eq_v  [NADDR];

  assign ref_v[0] = a_val_i;
  assign ref_v[1] = c_val_i;
  assign en_v[0]  = en_a_i;
  assign en_v[1]  = en_c_i & ~loop_sup_i;

  for (genvar g = 0; g < NADDR; g++) begin : g_addr_cmp
    assign eq_v[g] = valid_i & en_v[g] & (addr_i == ref_v[g]);
  end

  logic b_addr_eq, b_data_eq, ge_lo, le_hi, both_en;

  assign b_addr_eq = (addr_i == b_val_i[AW-1:0]);
  assign b_data_eq = (data_i == b_val_i[DW-1:0]);
  assign ge_lo     = (addr_i >= a_val_i);
  assign le_hi     = (addr_i <= b_val_i[AW-1:0]);
  assign both_en   = valid_i & en_a_i & en_b_i;

  assign ma_o      = eq_v[0];
  assign mc_o      = eq_v[1];
  assign mb_o      = valid_i & en_b_i & (full_i ? b_data_eq : b_addr_eq);
  assign in_rng_o  = both_en & ge_lo & le_hi;
  assign out_rng_o = both_en & ~(ge_lo & le_hi);
endmodule

// File: rtl/bts_trig_engine.sv
module bts_trig_engine
  import bts_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode_i,
  input  logic          full_i,
  input  logic          tag_i,
  input  logic          en_a_i,
  input  logic          en_b_i,
  input  logic          cfg_wr_i,
  input  logic          valid_i,
  input  logic [1:0]    ctype_i,
  input  logic [DW-1:0] data_i,
  input  logic          ma_i,
  input  logic          mb_i,
  input  logic          in_rng_i,
  input  logic          out_rng_i,
  output logic          fire_o,
  output logic          trig_o,
  output logic          evt_o,
  output logic [DW-1:0] evt_data_o
);
  logic          armed_q, armed_d;
  logic          trig_q, evt_q;
  logic [DW-1:0] evt_data_q;
  logic          hit, fire, seq_mode, evt_mode, insn;

  assign seq_mode = (mode_i == MODE_A_THEN_B) | (mode_i == MODE_A_THEN_EVT);
  assign evt_mode = (mode_i == MODE_EVT_B) | (mode_i == MODE_A_THEN_EVT);
  assign insn     = valid_i & (ctype_i == CT_INSN);

  always_comb begin
    unique case (mode_i)
      MODE_A:          hit = ma_i;
      MODE_A_OR_B:     hit = ma_i | mb_i;
      MODE_A_THEN_B:   hit = armed_q & mb_i;
      MODE_A_AND_B:    hit = full_i & ma_i & mb_i;
      MODE_A_NOT_B:    hit = full_i & ma_i & ~mb_i;
      MODE_EVT_B:      hit = mb_i;
      MODE_A_THEN_EVT: hit = armed_q & mb_i;
      MODE_INSIDE:     hit = in_rng_i;
      MODE_OUTSIDE:    hit = out_rng_i;
      default:         hit = 1'b0;
    endcase
  end

  assign fire = hit & (~tag_i | insn);

  always_comb begin
    armed_d = armed_q;
    if (cfg_wr_i)               armed_d = 1'b0;
    else if (fire)              armed_d = 1'b0;
    else if (seq_mode & ma_i)   armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      trig_q  <= fire;
      evt_q   <= fire & evt_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                evt_data_q <= '0;
    else if (fire & evt_mode)  evt_data_q <= data_i;
  end

  assign fire_o     = fire;
  assign trig_o     = trig_q;
  assign evt_o      = evt_q;
  assign evt_data_o = evt_data_q;

  a_r4_armed_first: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q && ($past(mode_i) == MODE_A_THEN_B || $past(mode_i) == MODE_A_THEN_EVT)
      |-> $past(armed_q));

  a_r5_full_only: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q && ($past(mode_i) == MODE_A_AND_B || $past(mode_i) == MODE_A_NOT_B)
      |-> $past(full_i));

  a_r7_evt_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> trig_q);

  a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past(valid_i && (en_a_i || en_b_i)));

  a_r8_tag_on_insn: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q && $past(tag_i) |-> $past(valid_i && ctype_i == CT_INSN));
endmodule

// File: rtl/bts_bp_ctrl.sv
module bts_bp_ctrl
  import bts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  logic [1:0] ctype_i,
  input  logic       ab_fire_i,
  input  logic       tag_ab_i,
  input  logic       mc_i,
  input  logic       tag_c_i,
  input  logic       act_swi_i,
  input  logic       cfg_wr_i,
  input  logic       bp_clr_i,
  output logic       bp_dbg_o,
  output logic       bp_swi_o
);
  logic insn, set, force_hit;
  logic pend_q, pend_d, req_q, req_d, swi_q, swi_d;

  assign insn      = valid_i & (ctype_i == CT_INSN);
  assign force_hit = (ab_fire_i & ~tag_ab_i) | (mc_i & ~tag_c_i);
  assign set       = (ab_fire_i & tag_ab_i) | (mc_i & tag_c_i & insn) | (pend_q & insn);

  always_comb begin
    pend_d = cfg_wr_i ? 1'b0 : ((pend_q & ~insn) | force_hit);
    req_d  = set | (req_q & ~bp_clr_i);
    swi_d  = (set & ~req_q) ? act_swi_i : swi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      swi_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
      swi_q  <= swi_d;
    end
  end

  assign bp_dbg_o = req_q & ~swi_q;
  assign bp_swi_o = req_q & swi_q;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !bp_clr_i |=> req_q);

  a_r9_rise_on_insn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(valid_i && ctype_i == CT_INSN));

  a_r10_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && $past(req_q) |-> $stable(bp_swi_o));
endmodule

// File: rtl/bus_trigger_seq.sv
module bus_trigger_seq
  import bts_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic [1:0]       bus_ctype,
  input  logic             bp_clr,
  output logic             trig,
  output logic             evt_valid,
  output logic [DW-1:0]    evt_data,
  output logic             bp_dbg_req,
  output logic             bp_swi_req
);
  localparam int BW = (AW > DW) ? AW : DW;

  ctrl_t         ctrl;
  logic [AW-1:0] a_val, c_val;
  logic [BW-1:0] b_val;
  logic          cfg_wr, ma, mb, mc, in_rng, out_rng, ab_fire;

  bts_cfg_regs #(.AW(AW), .DW(DW), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl_o(ctrl), .a_val_o(a_val), .b_val_o(b_val),
    .c_val_o(c_val), .cfg_wr_o(cfg_wr)
  );

  bts_comparators #(.AW(AW), .DW(DW)) u_cmp (
    .valid_i(bus_valid), .addr_i(bus_addr), .data_i(bus_data),
    .full_i(ctrl.full), .en_a_i(ctrl.en_a), .en_b_i(ctrl.en_b),
    .en_c_i(ctrl.en_c), .loop_sup_i(ctrl.loop_sup),
    .a_val_i(a_val), .b_val_i(b_val), .c_val_i(c_val),
    .ma_o(ma), .mb_o(mb), .mc_o(mc), .in_rng_o(in_rng), .out_rng_o(out_rng)
  );

  bts_trig_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .mode_i(ctrl.mode), .full_i(ctrl.full),
    .tag_i(ctrl.tag_ab), .en_a_i(ctrl.en_a), .en_b_i(ctrl.en_b),
    .cfg_wr_i(cfg_wr), .valid_i(bus_valid), .ctype_i(bus_ctype),
    .data_i(bus_data), .ma_i(ma), .mb_i(mb), .in_rng_i(in_rng),
    .out_rng_i(out_rng), .fire_o(ab_fire), .trig_o(trig),
    .evt_o(evt_valid), .evt_data_o(evt_data)
  );

  bts_bp_ctrl u_bp (
    .clk(clk), .rst_n(rst_n), .valid_i(bus_valid), .ctype_i(bus_ctype),
    .ab_fire_i(ab_fire), .tag_ab_i(ctrl.tag_ab), .mc_i(mc),
    .tag_c_i(ctrl.tag_c), .act_swi_i(ctrl.act_swi), .cfg_wr_i(cfg_wr),
    .bp_clr_i(bp_clr), .bp_dbg_o(bp_dbg_req), .bp_swi_o(bp_swi_req)
  );
endmodule

// File: tb/tb_bus_trigger_seq.sv
`timescale 1ns/1ps
module tb_bus_trigger_seq;
  localparam int AW = 4, DW = 4, CFG_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic [1:0] bus_ctype = '0;
  logic bp_clr = 1'b0;
  logic trig, evt_valid, bp_dbg_req, bp_swi_req;
  logic [DW-1:0] evt_data;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_armed = 0;

  always #5 clk = ~clk;

  bus_trigger_seq #(.AW(AW), .DW(DW), .CFG_W(CFG_W)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input int mode, input bit full, input bit ea,
      input bit eb, input bit ec, input bit tab, input bit tc, input bit swi, input bit lp);
    return {lp, swi, tc, tab, ec, eb, ea, full, 4'(mode)};
  endfunction

  task automatic wcfg(input int a, input int d);
    bus_valid = 0; cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = CFG_W'(d);
    @(negedge clk);
    cfg_we = 0;
    m_armed = 0;
  endtask

  task automatic cyc(input bit v, input int a, input int d, input int ct);
    bus_valid = v; bus_addr = AW'(a); bus_data = DW'(d); bus_ctype = 2'(ct);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic clr_bp();
    bp_clr = 1; cyc(0, 0, 0, 0); bp_clr = 0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 trig", trig, 0);
    check("R12 evt", evt_valid, 0);
    check("R12 bp", {bp_dbg_req, bp_swi_req}, 0);

    // R1: register select and control layout
    wcfg(0, mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
    wcfg(1, 12);
    cyc(1, 12, 0, 0); check("R1 A value match", trig, 1);
    cyc(1, 5, 0, 0);  check("R1 A value miss", trig, 0);

    // Sweep: modes 0..9, full, enable pairs, two data passes
    bp_clr = 1;
    wcfg(1, 5); wcfg(2, 9);
    for (int mode = 0; mode < 10; mode++)
      for (int full = 0; full < 2; full++)
        for (int en = 0; en < 4; en++) begin
          bit ea = en[0], eb = en[1];
          string tagn;
          wcfg(0, mk(mode, full[0], ea, eb, 0, 0, 0, 0, 0));
          if (!ea && !eb) tagn = "R2";
          else if (mode == 2 || mode == 6) tagn = "R4";
          else if (mode == 3 || mode == 4 || mode == 9) tagn = "R5";
          else if (mode == 7 || mode == 8) tagn = "R6";
          else tagn = "R3";
          for (int p = 0; p < 2; p++)
            for (int i = 0; i < 16; i++) begin
              int ad = (i * 7) % 16;
              int dt = (i * 3 + p * 5) % 16;
              bit ma = ea && ad == 5;
              bit mb = eb && (full ? dt == 9 : ad == 9);
              bit ins = ea && eb && ad >= 5 && ad <= 9;
              bit hit;
              case (mode)
                0: hit = ma;
                1: hit = ma || mb;
                2, 6: hit = m_armed && mb;
                3: hit = full && ma && mb;
                4: hit = full && ma && !mb;
                5: hit = mb;
                7: hit = ins;
                8: hit = ea && eb && !ins;
                default: hit = 0;
              endcase
              if (mode == 2 || mode == 6) begin
                if (hit) m_armed = 0;
                else if (ma) m_armed = 1;
              end
              cyc(1, ad, dt, 0);
              check(tagn, trig, int'(hit));
              check("R7 evt strobe", evt_valid, int'(hit && (mode == 5 || mode == 6)));
              if (hit && (mode == 5 || mode == 6)) check("R7 evt data", evt_data, dt);
            end
        end
    bp_clr = 0;
    clr_bp();

    // R4: configuration write drops the armed state
    wcfg(0, mk(2, 0, 1, 1, 0, 0, 0, 0, 0));
    cyc(1, 5, 0, 0); check("R4 A alone", trig, 0);
    wcfg(3, 1);
    cyc(1, 9, 0, 0); check("R4 disarmed by write", trig, 0);
    cyc(1, 5, 0, 0); cyc(1, 9, 0, 0); check("R4 rearmed fires", trig, 1);
    clr_bp();

    // R8: tag
    wcfg(0, mk(0, 0, 1, 0, 0, 1, 0, 0, 0));
    cyc(1, 5, 0, 0); check("R8 non-insn trig", trig, 0);
    check("R8 non-insn bp", bp_dbg_req, 0);
    cyc(1, 5, 0, 1); check("R8 insn trig", trig, 1);
    check("R8 insn bp", bp_dbg_req, 1);
    cyc(0, 0, 0, 0); check("R10 held", bp_dbg_req, 1);
    check("R3 pulse width", trig, 0);
    clr_bp(); check("R10 cleared", bp_dbg_req, 0);

    // R9: force with software-interrupt action
    wcfg(0, mk(0, 0, 1, 0, 0, 0, 0, 1, 0));
    cyc(1, 5, 0, 0); check("R9 trig", trig, 1);
    check("R9 not yet", {bp_dbg_req, bp_swi_req}, 0);
    cyc(1, 3, 0, 0); check("R9 wait boundary", {bp_dbg_req, bp_swi_req}, 0);
    cyc(1, 3, 0, 1); check("R10 swi route", bp_swi_req, 1);
    check("R10 dbg quiet", bp_dbg_req, 0);
    clr_bp();
    cyc(1, 5, 0, 1); check("R9 match on insn not same", bp_swi_req, 0);
    cyc(1, 6, 0, 1); check("R9 next insn", bp_swi_req, 1);
    clr_bp();

    // R11: comparator C
    wcfg(3, 3);
    wcfg(0, mk(15, 0, 0, 0, 1, 0, 1, 0, 0));
    cyc(1, 3, 0, 1); check("R11 C tag", bp_dbg_req, 1);
    clr_bp();
    wcfg(0, mk(15, 0, 0, 0, 1, 0, 1, 0, 1));
    cyc(1, 3, 0, 1); check("R11 loop gate", bp_dbg_req, 0);
    cyc(1, 0, 0, 1); check("R11 loop gate later", bp_dbg_req, 0);
    wcfg(0, mk(15, 0, 0, 0, 1, 0, 0, 0, 0));
    cyc(1, 3, 0, 0); check("R11 C force wait", bp_dbg_req, 0);
    cyc(1, 0, 0, 1); check("R11 C force", bp_dbg_req, 1);
    clr_bp();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule